// File: doc/BRIEF.md
# Strip-Mined Vector Length Sequencer

This block sequences a long element-wise vector operation as a series of chunks. No chunk is longer than the maximum vector length of 64 elements. A single-cycle start pulse supplies the total element count N and three base addresses: two source operands and one destination. The block then presents one chunk descriptor at a time. A descriptor holds the chunk length and the current address of each of the three operands. The descriptor waits until the downstream vector engine accepts it with a ready signal.

The odd-sized piece goes first. The first chunk covers N modulo 64 elements, and every chunk after it covers the full 64. After each accepted chunk, every pointer advances by the chunk length times the 8-byte element size, and the remaining count drops by the same length. A count that is an exact multiple of 64 never produces an empty chunk. A zero count finishes at once. A one-cycle done pulse marks the end of each run.

Top module: `vlen_seq`

## Requirements
- R1: While reset is applied and after it is released, chunk_valid_o, done_o and busy_o are all 0 until a start is taken.
- R2: When N mod 64 is nonzero, the first descriptor has chunk_len_o equal to the low 6 bits of N and carries the three base addresses unchanged.
- R3: Every descriptor after the first has chunk_len_o equal to 64.
- R4: After a descriptor is accepted (chunk_valid_o and chunk_ready_i both high at a clock edge), each of the three addresses in the next descriptor equals the previous address plus 8 times the accepted length.
- R5: The accepted chunk lengths of one run add up to exactly N.
- R6: No descriptor has length 0. When N is a nonzero multiple of 64, every chunk is 64 long.
- R7: A start with N equal to 0 raises done_o in the cycle after the start edge and issues no descriptor.
- R8: While chunk_valid_o is high and chunk_ready_i is low, the length and the addresses stay unchanged into the next cycle, and chunk_valid_o stays high.
- R9: done_o is high for exactly one cycle: the cycle after the last descriptor is accepted (or the one R7 gives). busy_o is high from the cycle after an accepted start through the done cycle.
- R10: A start pulse while busy_o is high has no effect on the descriptors issued or on the run's total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only while idle |
| count_i | input | 32 | Total element count N |
| base_a_i | input | 32 | Base byte address of source A |
| base_b_i | input | 32 | Base byte address of source B |
| base_c_i | input | 32 | Base byte address of destination C |
| chunk_ready_i | input | 1 | Downstream accepts the current descriptor |
| chunk_valid_o | output | 1 | Descriptor valid |
| chunk_len_o | output | 7 | Chunk length, 1 to 64 |
| addr_a_o | output | 32 | Current address of A |
| addr_b_o | output | 32 | Current address of B |
| addr_c_o | output | 32 | Current address of C |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |

## Verification
The bench applies several counts, and each one separates a different piece of the length logic:
- A count with a nonzero remainder and several full chunks (150, 1000) shows that the short piece comes first.
- A count below 64 (40, 1) checks the single-chunk path.
- Exact multiples of 64 (64, 128) expose any empty chunk.
- A zero count tests the immediate finish.

Runs alternate between a ready that is always high and a pseudo-random ready. The random ready separates correct holding of a descriptor from advancing early. A start pulse injected during a run tests that the block ignores it.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DONE  = 2'd2
  } vseq_state_e;
endpackage

// File: rtl/vseq_len.sv
module vseq_len #(
  parameter int CNT_W    = 32,
  parameter int MVL_LOG2 = 6,
  localparam int LEN_W   = MVL_LOG2 + 1
) (
  input  logic [CNT_W-1:0] rem_i,
  output logic [LEN_W-1:0] len_o
);
  localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(1) << MVL_LOG2;

  logic [MVL_LOG2-1:0] tail;

  always_comb begin
    tail = rem_i[MVL_LOG2-1:0];
    // Only the first chunk can have a nonzero tail: after it, the remainder is a multiple of MVL.
    if (tail != '0) len_o = {1'b0, tail};
    else            len_o = FULL_LEN;
  end
endmodule

// File: rtl/vseq_rem.sv
module vseq_rem #(
  parameter int CNT_W = 32,
  parameter int LEN_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             dec_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [CNT_W-1:0] rem_o,
  output logic             last_o
);
  logic [CNT_W-1:0] rem_d;
  logic             rem_en;

  always_comb begin
    rem_en = load_i | dec_i;
    rem_d  = rem_o;
    if (load_i)     rem_d = count_i;
    else if (dec_i) rem_d = rem_o - CNT_W'(len_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rem_o <= '0;
    else if (rem_en) rem_o <= rem_d;
  end

  assign last_o = (rem_o == CNT_W'(len_i));
endmodule

// File: rtl/vseq_ptr.sv
module vseq_ptr #(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 7,
  parameter int ELEM_LOG2 = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              step_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [ADDR_W-1:0] ptr_o
);
  logic [ADDR_W-1:0] ptr_d;
  logic              ptr_en;

  always_comb begin
    ptr_en = load_i | step_i;
    ptr_d  = ptr_o;
    if (load_i)      ptr_d = base_i;
    else if (step_i) ptr_d = ptr_o + (ADDR_W'(len_i) << ELEM_LOG2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_o <= '0;
    else if (ptr_en) ptr_o <= ptr_d;
  end
endmodule

// File: rtl/vlen_seq.sv
module vlen_seq #(
  parameter int CNT_W     = 32,
  parameter int ADDR_W    = 32,
  parameter int MVL_LOG2  = 6,
  parameter int ELEM_LOG2 = 3,
  localparam int LEN_W    = MVL_LOG2 + 1,
  localparam int N_PTR    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [ADDR_W-1:0] base_a_i,
  input  logic [ADDR_W-1:0] base_b_i,
  input  logic [ADDR_W-1:0] base_c_i,
  input  logic              chunk_ready_i,
  output logic              chunk_valid_o,
  output logic [LEN_W-1:0]  chunk_len_o,
  output logic [ADDR_W-1:0] addr_a_o,
  output logic [ADDR_W-1:0] addr_b_o,
  output logic [ADDR_W-1:0] addr_c_o,
  output logic              busy_o,
  output logic              done_o
);
  import vseq_pkg::*;

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  vseq_state_e state_q, state_d;
  logic        take_start, accept, load, last;
  logic [CNT_W-1:0]  rem;
  logic [ADDR_W-1:0] base_arr [N_PTR];
  logic [ADDR_W-1:0] ptr_arr  [N_PTR];

  assign take_start = (state_q == ST_IDLE) && start_i;
  assign load       = take_start && (count_i != '0);
  assign accept     = chunk_valid_o && chunk_ready_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (take_start) state_d = (count_i == '0) ? ST_DONE : ST_ISSUE;
      ST_ISSUE: if (accept && last) state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) state_q <= ST_IDLE;
    else            state_q <= state_d;
  end

  vseq_rem #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_rem (
    .clk(clk), .rst_n(rst_int_n), .load_i(load), .count_i(count_i),
    .dec_i(accept), .len_i(chunk_len_o), .rem_o(rem), .last_o(last)
  );

  vseq_len #(.CNT_W(CNT_W), .MVL_LOG2(MVL_LOG2)) u_len (
    .rem_i(rem), .len_o(chunk_len_o)
  );

  assign base_arr[0] = base_a_i;
  assign base_arr[1] = base_b_i;
  assign base_arr[2] = base_c_i;

  for (genvar g = 0; g < N_PTR; g++) begin : g_ptr
    vseq_ptr #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .ELEM_LOG2(ELEM_LOG2)) u_ptr (
      .clk(clk), .rst_n(rst_int_n), .load_i(load), .base_i(base_arr[g]),
      .step_i(accept), .len_i(chunk_len_o), .ptr_o(ptr_arr[g])
    );
  end

  assign addr_a_o      = ptr_arr[0];
  assign addr_b_o      = ptr_arr[1];
  assign addr_c_o      = ptr_arr[2];
  assign chunk_valid_o = (state_q == ST_ISSUE);
  assign busy_o        = (state_q != ST_IDLE);
  assign done_o        = (state_q == ST_DONE);

  // Assertions
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    !busy_o |-> (!chunk_valid_o && !done_o));

  assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    accept |=> addr_a_o == ($past(addr_a_o) + (ADDR_W'($past(chunk_len_o)) << ELEM_LOG2)));

  assert_len_range_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    chunk_valid_o |-> (chunk_len_o != '0 && chunk_len_o <= (LEN_W'(1) << MVL_LOG2)));

  assert_zero_count_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (take_start && count_i == '0) |=> (done_o && !chunk_valid_o));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (chunk_valid_o && !chunk_ready_i) |=>
      (chunk_valid_o && $stable(chunk_len_o) && $stable(addr_a_o)
       && $stable(addr_b_o) && $stable(addr_c_o)));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    done_o |=> !done_o);

  assert_busy_start_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (chunk_valid_o && start_i && !accept) |=> chunk_valid_o);
endmodule

// File: tb/vlen_seq_tb.sv
module vlen_seq_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, start_i, chunk_ready_i;
  logic [31:0] count_i, base_a_i, base_b_i, base_c_i;
  logic        chunk_valid_o, busy_o, done_o;
  logic [6:0]  chunk_len_o;
  logic [31:0] addr_a_o, addr_b_o, addr_c_o;

  vlen_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .count_i(count_i),
    .base_a_i(base_a_i), .base_b_i(base_b_i), .base_c_i(base_c_i),
    .chunk_ready_i(chunk_ready_i), .chunk_valid_o(chunk_valid_o),
    .chunk_len_o(chunk_len_o), .addr_a_o(addr_a_o), .addr_b_o(addr_b_o),
    .addr_c_o(addr_c_o), .busy_o(busy_o), .done_o(done_o)
  );

  typedef struct packed {
    logic [6:0]  len;
    logic [31:0] a, b, c;
    logic [3:0]  tag;  // 2: first chunk, 3: later chunk, 6: multiple-of-64 run
  } exp_t;

  exp_t        exp_q[$];
  int          checks = 0, failures = 0, done_cnt = 0;
  longint      sum_len = 0;
  logic        done_due = 1'b0, rdy_mode = 1'b0, mon_en = 1'b0, finished = 1'b0;
  logic        prev_hold = 1'b0;
  logic [7:0]  lfsr = 8'hA5;
  logic [6:0]  prev_len;
  logic [31:0] prev_a, prev_b, prev_c;

  task automatic chk(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s", msg);
    end
  endtask

  // Monitor / scoreboard, sampling at the falling edge
  always @(negedge clk) begin
    if (mon_en) begin
      logic new_due;
      exp_t e;
      new_due = 1'b0;
      // R9: done only where expected
      chk(done_o == done_due, $sformatf("R9 done_o act=%0b exp=%0b", done_o, done_due));
      if (done_o) done_cnt++;
      if (start_i && !busy_o && count_i == 0) new_due = 1'b1;
      // R8: held descriptor
      if (prev_hold)
        chk(chunk_valid_o && chunk_len_o == prev_len && addr_a_o == prev_a
            && addr_b_o == prev_b && addr_c_o == prev_c,
            $sformatf("R8 hold act=v%0b len%0d a%h exp=v1 len%0d a%h",
                      chunk_valid_o, chunk_len_o, addr_a_o, prev_len, prev_a));
      // next ready
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      chunk_ready_i = rdy_mode ? lfsr[0] : 1'b1;
      prev_hold = chunk_valid_o && !chunk_ready_i;
      prev_len = chunk_len_o; prev_a = addr_a_o; prev_b = addr_b_o; prev_c = addr_c_o;
      if (chunk_valid_o && chunk_ready_i) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, $sformatf("R7 unexpected descriptor len act=%0d exp=none", chunk_len_o));
        end else begin
          e = exp_q.pop_front();
          sum_len += chunk_len_o;
          case (e.tag)
            4'd2: chk(chunk_len_o == e.len, $sformatf("R2 len act=%0d exp=%0d", chunk_len_o, e.len));
            4'd6: chk(chunk_len_o == e.len, $sformatf("R6 len act=%0d exp=%0d", chunk_len_o, e.len));
            default: chk(chunk_len_o == e.len, $sformatf("R3 len act=%0d exp=%0d", chunk_len_o, e.len));
          endcase
          chk(addr_a_o == e.a && addr_b_o == e.b && addr_c_o == e.c,
              $sformatf("R4 addr act=%h/%h/%h exp=%h/%h/%h",
                        addr_a_o, addr_b_o, addr_c_o, e.a, e.b, e.c));
          if (exp_q.size() == 0) new_due = 1'b1;
        end
      end
      done_due = new_due;
    end
  end

  task automatic run_vec(input int unsigned n, input logic [31:0] a, b, c,
                         input bit intrude);
    int unsigned rem, l;
    logic [31:0] pa, pb, pc;
    bit first;
    int start_done;
    exp_t e;
    while (busy_o) @(posedge clk);
    rem = n; pa = a; pb = b; pc = c; first = 1'b1;
    while (rem > 0) begin
      l = (rem % 64 != 0) ? rem % 64 : 64;
      e.len = 7'(l); e.a = pa; e.b = pb; e.c = pc;
      e.tag = (n % 64 == 0) ? 4'd6 : (first ? 4'd2 : 4'd3);
      exp_q.push_back(e);
      rem -= l; pa += l * 8; pb += l * 8; pc += l * 8; first = 1'b0;
    end
    sum_len = 0;
    start_done = done_cnt;
    @(posedge clk); #1;
    start_i = 1'b1; count_i = n; base_a_i = a; base_b_i = b; base_c_i = c;
    @(posedge clk); #1;
    start_i = 1'b0;
    @(negedge clk);
    if (n == 0) chk(done_o && !chunk_valid_o, $sformatf("R7 done=%0b valid=%0b exp=1/0", done_o, chunk_valid_o));
    else        chk(busy_o && chunk_valid_o, $sformatf("R9 busy=%0b valid=%0b exp=1/1", busy_o, chunk_valid_o));
    if (intrude) begin
      // R10: start while busy, different parameters
      @(posedge clk); #1;
      start_i = 1'b1; count_i = 5; base_a_i = 32'hDEAD0000;
      @(posedge clk); #1;
      start_i = 1'b0;
    end
    while (done_cnt == start_done) @(posedge clk);
    chk(sum_len == n, $sformatf("R5 total act=%0d exp=%0d", sum_len, n));
    if (intrude) chk(exp_q.size() == 0, $sformatf("R10 leftover act=%0d exp=0", exp_q.size()));
    @(negedge clk);
    chk(!busy_o && !done_o, $sformatf("R9 after done busy=%0b done=%0b exp=0/0", busy_o, done_o));
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; chunk_ready_i = 1'b1;
    count_i = '0; base_a_i = '0; base_b_i = '0; base_c_i = '0;
    repeat (3) @(negedge clk);
    chk(!chunk_valid_o && !done_o && !busy_o, "R1 in reset outputs act=nonzero exp=0");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!chunk_valid_o && !done_o && !busy_o,
        $sformatf("R1 after reset v=%0b d=%0b b=%0b exp=0", chunk_valid_o, done_o, busy_o));
    mon_en = 1'b1;
    run_vec(150,  32'h0000_1000, 32'h0001_0000, 32'h0002_0000, 1'b0);
    run_vec(40,   32'h0000_2000, 32'h0003_0008, 32'h0004_0010, 1'b0);
    run_vec(128,  32'h0010_0000, 32'h0020_0000, 32'h0030_0000, 1'b0);
    run_vec(0,    32'h0000_0100, 32'h0000_0200, 32'h0000_0300, 1'b0);
    run_vec(1,    32'hFFFF_FFF8, 32'h0000_0008, 32'h0000_0010, 1'b0);
    rdy_mode = 1'b1;
    run_vec(1000, 32'h0100_0000, 32'h0200_0000, 32'h0300_0000, 1'b0);
    run_vec(64,   32'h0000_4000, 32'h0000_8000, 32'h0000_C000, 1'b0);
    run_vec(300,  32'h0A00_0000, 32'h0B00_0000, 32'h0C00_0000, 1'b1);
    run_vec(0,    32'h0, 32'h0, 32'h0, 1'b0);
    run_vec(193,  32'h0000_0000, 32'h1000_0000, 32'h2000_0000, 1'b0);
    repeat (5) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule